// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out a single loop primitive of a small processor core. It steps a counter register down by one or up by one, or leaves it as it is, and in the same operation it decides whether to branch by testing the updated value for zero. One control byte, the postbyte, carries all of the settings: the operation, the branch sense, the sign of the displacement and the register to use. A second byte carries the low eight bits of a 9-bit signed displacement.

The sequencer presents the postbyte, the displacement byte and the program counter, which already points past the instruction. It then raises `start` for one cycle. The unit drives the read selector straight from the postbyte, so the register file can return the operand in that same cycle. One clock later the unit raises `done` for one cycle. In that cycle it also presents a write strobe with the write selector and data, the branch decision, and the next program counter.

Registers 0 to 2 are 8 bits wide. Registers 3 to 7 are 16 bits wide.

Top module: `loop_branch_unit`

## Requirements
- R1: Postbyte bits 7:6 select the operation. 00 subtracts one from the selected register, 01 leaves it unchanged, and 10 adds one. The result appears on `reg_wdata`.
- R2: The operation code 11 is illegal. With `done` it raises `err`, and it leaves `reg_we` low, `taken` low and `next_pc` equal to `pc_in`.
- R3: The branch target is `pc_in` plus the 9-bit signed offset {postbyte[4], disp_lo}, taken modulo 2^16.
- R4: When postbyte bit 5 is 1, the branch is taken if the updated value is nonzero. When bit 5 is 0, the branch is taken if the updated value is zero.
- R5: Postbyte bits 2:0 are the register index. `rd_sel` follows them combinationally, and `wr_sel` returns them together with `done`. Bit 3 has no effect.
- R6: For indices 0, 1 and 2 (the 8-bit registers), the step wraps within 8 bits and the zero test uses only the low byte. Bits 15:8 of `reg_wdata` are 0 and the upper byte of `reg_rdata` is ignored.
- R7: Every legal operation pulses `reg_we` with `done`, whether or not the branch is taken.
- R8: When the branch is not taken, `next_pc` equals `pc_in`.
- R9: `done` is high exactly in the cycle after a `start` cycle. Reset clears `done`, `err`, `taken`, `reg_we`, `wr_sel`, `reg_wdata` and `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that launches an operation |
| postbyte | input | 8 | Operation, branch sense, displacement sign and register index |
| disp_lo | input | 8 | Low eight bits of the displacement |
| pc_in | input | 16 | Program counter, already past the instruction |
| reg_rdata | input | 16 | Value of the register named by `rd_sel` |
| rd_sel | output | 3 | Register read index |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal operation code, valid with `done` |
| reg_we | output | 1 | Register write strobe |
| wr_sel | output | 3 | Register write index |
| reg_wdata | output | 16 | Updated register value |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Next program counter |

## Verification
The hardest cases to reach are those where the 8-bit registers and the 16-bit registers have to give different results. One example is an operand such as 0x0100 on an 8-bit register, where the low byte is zero but the full word is not. Another is a target that crosses the top or bottom of the 16-bit address space. The bench sweeps all 256 postbytes against operand words that have garbage in the upper byte, the low-byte wrap points and the 16-bit wrap points. It pairs them with displacements at both extremes and with program counters close to either end of the address space, so that every one of these cases occurs.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_BAD = 2'b11
  } loop_op_e;

  typedef struct packed {
    loop_op_e   op;
    logic       on_nonzero;
    logic       disp_neg;
    logic [2:0] sel;
  } loop_ctl_t;

  localparam int NARROW_COUNT = 3;
endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
(
  input  logic [7:0] pb,
  output loop_ctl_t  ctl,
  output logic       narrow,
  output logic       illegal
);
  logic unused_pb3;
  assign unused_pb3 = pb[3];

  always_comb begin
    ctl.op         = loop_op_e'(pb[7:6]);
    ctl.on_nonzero = pb[5];
    ctl.disp_neg   = pb[4];
    ctl.sel        = pb[2:0];
    narrow         = (32'(pb[2:0]) < NARROW_COUNT);
    illegal        = (pb[7:6] == OP_BAD);
  end
endmodule

// File: rtl/lcb_counter.sv
module lcb_counter
  import lcb_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  loop_op_e          op,
  input  logic              narrow,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] next_val,
  output logic              is_zero
);
  localparam int PAD_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] mask;

  always_comb begin
    unique case (op)
      OP_DEC:  step = '1;
      OP_INC:  step = DATA_W'(1);
      default: step = '0;
    endcase
    sum      = value + step;
    mask     = narrow ? NARROW_MASK : '1;
    next_val = sum & mask;
    is_zero  = (next_val == '0);
  end
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 9
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              disp_neg,
  input  logic [DISP_W-2:0] disp_lo,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - DISP_W + 1;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = {{EXT_W{disp_neg}}, disp_lo};
    target = pc + offset;
  end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DISP_W   = 9,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        postbyte,
  input  logic [DISP_W-2:0] disp_lo,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              done,
  output logic              err,
  output logic              reg_we,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  loop_ctl_t         ctl;
  logic              narrow;
  logic              illegal;
  logic [DATA_W-1:0] upd_val;
  logic              upd_zero;
  logic [ADDR_W-1:0] target;
  logic              take_now;

  lcb_decode u_dec (
    .pb      (postbyte),
    .ctl     (ctl),
    .narrow  (narrow),
    .illegal (illegal)
  );

  lcb_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .op       (ctl.op),
    .narrow   (narrow),
    .value    (reg_rdata),
    .next_val (upd_val),
    .is_zero  (upd_zero)
  );

  lcb_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc       (pc_in),
    .disp_neg (ctl.disp_neg),
    .disp_lo  (disp_lo),
    .target   (target)
  );

  assign rd_sel   = ctl.sel[SEL_W-1:0];
  assign take_now = !illegal && (ctl.on_nonzero ? !upd_zero : upd_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      err       <= 1'b0;
      reg_we    <= 1'b0;
      wr_sel    <= '0;
      reg_wdata <= '0;
      taken     <= 1'b0;
      next_pc   <= '0;
    end else if (start) begin
      done      <= 1'b1;
      err       <= illegal;
      reg_we    <= !illegal;
      wr_sel    <= ctl.sel[SEL_W-1:0];
      reg_wdata <= illegal ? '0 : upd_val;
      taken     <= take_now;
      next_pc   <= take_now ? target : pc_in;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      reg_we <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_branch_unit_chk.sv
module loop_branch_unit_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int SEL_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] pc_in,
  input logic              done,
  input logic              err,
  input logic              reg_we,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc
);
  // R9: completion follows a start by exactly one cycle
  assert_done_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  // R2: an illegal code never writes and never branches
  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !reg_we && !taken));

  // R7: every legal completion writes back
  assert_writeback_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> reg_we);

  // R8: not taken keeps the incoming program counter
  assert_fallthrough_pc_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> (taken || (next_pc == $past(pc_in))));

  // R6: narrow registers never receive upper-byte bits
  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (32'(wr_sel) < 3)) |-> (reg_wdata[DATA_W-1:NARROW_W] == '0));
endmodule

bind loop_branch_unit loop_branch_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .done(done),
  .err(err), .reg_we(reg_we), .wr_sel(wr_sel), .reg_wdata(reg_wdata),
  .taken(taken), .next_pc(next_pc)
);

// File: tb/loop_branch_unit_test.sv
`timescale 1ns/1ps
module loop_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [7:0]  disp_lo = '0;
  logic [15:0] pc_in = '0;
  logic [15:0] reg_rdata = '0;
  logic [2:0]  rd_sel;
  logic        done, err, reg_we, taken;
  logic [2:0]  wr_sel;
  logic [15:0] reg_wdata, next_pc;

  int tests_run = 0;
  int tests_failed = 0;

  always #4 clk = ~clk;

  loop_branch_unit uut (
    .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
    .disp_lo(disp_lo), .pc_in(pc_in), .reg_rdata(reg_rdata),
    .rd_sel(rd_sel), .done(done), .err(err), .reg_we(reg_we),
    .wr_sel(wr_sel), .reg_wdata(reg_wdata), .taken(taken), .next_pc(next_pc)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] pb, input logic [7:0] d,
                         input logic [15:0] pc, input logic [15:0] rv);
    int          op;
    bit          nar, exp_take;
    logic [15:0] val, upd, tgt, off;
    op  = int'(pb[7:6]);
    nar = (pb[2:0] < 3'd3);
    val = nar ? {8'h00, rv[7:0]} : rv;
    case (op)
      0: upd = val - 16'd1;
      2: upd = val + 16'd1;
      default: upd = val;
    endcase
    if (nar) upd = upd & 16'h00FF;
    off = {{8{pb[4]}}, d};
    tgt = pc + off;
    exp_take = (op != 3) && (pb[5] ? (upd != 0) : (upd == 0));

    postbyte = pb; disp_lo = d; pc_in = pc; reg_rdata = rv; start = 1'b1;
    #1;
    chk("R5", "rd_sel", 32'(rd_sel), 32'(pb[2:0]));
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done", 32'(done), 1);
    chk("R2", "err", 32'(err), (op == 3) ? 1 : 0);
    chk("R7", "reg_we", 32'(reg_we), (op == 3) ? 0 : 1);
    chk("R5", "wr_sel", 32'(wr_sel), 32'(pb[2:0]));
    chk("R4", "taken", 32'(taken), 32'(exp_take));
    if (op != 3)
      chk(nar ? "R6" : "R1", "reg_wdata", 32'(reg_wdata), 32'(upd));
    if (exp_take) chk("R3", "next_pc", 32'(next_pc), 32'(tgt));
    else          chk("R8", "next_pc", 32'(next_pc), 32'(pc));
  endtask

  initial begin
    logic [15:0] rvals [6];
    logic [7:0]  dvals [4];
    logic [15:0] pcs   [2];
    rvals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h00FF, 16'h0100, 16'h8000};
    dvals = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    pcs   = '{16'h0010, 16'hFFF0};
    repeat (3) @(negedge clk);
    chk("R9", "reset done", 32'(done), 0);
    chk("R9", "reset err", 32'(err), 0);
    chk("R9", "reset reg_we", 32'(reg_we), 0);
    chk("R9", "reset taken", 32'(taken), 0);
    chk("R9", "reset next_pc", 32'(next_pc), 0);
    chk("R9", "reset reg_wdata", 32'(reg_wdata), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 256; p++)
      for (int r = 0; r < 6; r++)
        for (int di = 0; di < 4; di++)
          for (int q = 0; q < 2; q++)
            run_one(8'(p), dvals[di], pcs[q], rvals[r]);
    // R9: pulse ends when no new start arrives
    @(negedge clk);
    chk("R9", "idle done", 32'(done), 0);
    chk("R7", "idle reg_we", 32'(reg_we), 0);
    chk("R2", "idle err", 32'(err), 0);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule